// File: doc/BRIEF.md
# Pulse-Width Status Strobe Encoder

This block sits beside a core instruction sequencer. It turns the sequencer's one-cycle event requests into pulses on a single status wire, and it raises a separate refill strobe when the pipeline must be refilled. An observer outside the core reads the status wire and tells the event class apart by the number of consecutive high clocks. A plain instruction boundary gives one clock. A boundary held back by a pending trace or interrupt gives two. A translation-cache miss or the start of exception processing gives three. A sequencer that has shut down after a double bus fault holds the wire high without end.

Pulses are kept apart by at least one low clock, so back-to-back events stay readable. One event can wait while a pulse is being sent. A further event that arrives while that slot is full is dropped and reported. A halt request overrides whatever is running or waiting. The refill strobe is decoded from a cause code that comes with each retired operation, and it works independently of the status pulses.

Top module: `seq_strobe_encoder`

## Requirements
- R1: An accepted event of kind 0 (plain boundary) drives `status_o` high for exactly 1 clock, starting the clock after the request when the encoder is idle.
- R2: An accepted event of kind 1 (deferred boundary: trace or interrupt pending) drives `status_o` high for exactly 2 clocks.
- R3: An accepted event of kind 2 (translation miss or exception start) drives `status_o` high for exactly 3 clocks.
- R4: A `halt_req_i` pulse makes `status_o` high from the next clock and keeps it high until reset. It discards any running or waiting event, and later events cause neither a pulse change nor an overflow.
- R5: `refill_o` is high for one clock, the clock after `op_valid_i`, when `op_cause_i` is one of 1 branch, 2 jump, 3 trap, 4 return, 5 flow-changing coprocessor op, 6 exception, 7 status-register write or 8 translation-control write.
- R6: Cause 0 (an arithmetic or logic op that changes only condition codes) and the unused causes 9 to 15 never raise `refill_o`.
- R7: Between two status pulses `status_o` is low for at least GAP_CYCLES clocks (default 1). A waiting event starts right after that gap.
- R8: One event can wait while a pulse or gap is running. An event that arrives while the wait slot is full and cannot move forward is dropped, and `overflow_o` is high for the following clock.
- R9: `busy_o` is high from the clock after an event is accepted until the gap after the last pulse ends. It is low otherwise, except during halt, when it stays high.
- R10: Synchronous active-high `rst` leaves `status_o`, `refill_o`, `busy_o` and `overflow_o` low on the clock after it is sampled, and it clears the waiting event and the halt state.
- R11: Kind 3 is reserved. A request with kind 3 produces no pulse and leaves `busy_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_valid_i | input | 1 | One-cycle event request |
| ev_kind_i | input | 2 | Event class: 0 plain, 1 deferred, 2 exception/miss, 3 reserved |
| halt_req_i | input | 1 | Double-fault halt request |
| op_valid_i | input | 1 | A retired operation reports its refill cause |
| op_cause_i | input | 4 | Refill cause code (see R5, R6) |
| status_o | output | 1 | Pulse-width coded status strobe |
| refill_o | output | 1 | Pipeline refill strobe |
| busy_o | output | 1 | A pulse, gap or waiting event is in progress |
| overflow_o | output | 1 | An event was dropped on the previous clock |

## Verification
Each event kind is sent alone into an idle encoder. The measured high run then separates the one-, two- and three-clock encodings, and the reserved kind is shown to produce no pulse. A three-clock pulse followed at once by a one-clock event shows both the gap and that the waiting event starts on time. Three events in consecutive clocks fill the wait slot and show that only the third is dropped. A halt issued in the middle of a pulse with an event waiting shows the override, and a reset afterwards shows the halt state clearing. All sixteen cause codes are swept to separate the refilling causes from the rest.

// File: rtl/seq_strobe_pkg.sv
package seq_strobe_pkg;

  typedef enum logic [1:0] {
    EVK_PLAIN = 2'd0,
    EVK_DEFER = 2'd1,
    EVK_TRAP  = 2'd2,
    EVK_RSVD  = 2'd3
  } ev_kind_e;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_PULSE = 2'd1,
    ENG_GAP   = 2'd2,
    ENG_HALT  = 2'd3
  } eng_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/seq_pulse_engine.sv
module seq_pulse_engine
  import seq_strobe_pkg::*;
#(
  parameter int CNT_W      = 2,
  parameter int GAP_CYCLES = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halt_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] start_len_i,
  output logic             can_start_o,
  output logic             status_o,
  output logic             halted_o,
  output logic             active_o
);

  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_CYCLES - 1);

  eng_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  // Starting is allowed from idle, or on the final gap clock so that
  // a waiting event follows with exactly GAP_CYCLES low clocks.
  assign can_start_o = (state_q == ENG_IDLE) ||
                       ((state_q == ENG_GAP) && (cnt_q == '0));
  assign halted_o    = (state_q == ENG_HALT);
  assign active_o    = (state_q != ENG_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ENG_IDLE;
      cnt_q    <= '0;
      status_o <= 1'b0;
    end else if (halt_i || state_q == ENG_HALT) begin
      state_q  <= ENG_HALT;
      cnt_q    <= '0;
      status_o <= 1'b1;
    end else begin
      unique case (state_q)
        ENG_IDLE: begin
          if (start_i) begin
            state_q  <= ENG_PULSE;
            cnt_q    <= start_len_i - ONE;
            status_o <= 1'b1;
          end
        end
        ENG_PULSE: begin
          if (cnt_q == '0) begin
            state_q  <= ENG_GAP;
            cnt_q    <= GAP_LAST;
            status_o <= 1'b0;
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
        ENG_GAP: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
          end else if (start_i) begin
            state_q  <= ENG_PULSE;
            cnt_q    <= start_len_i - ONE;
            status_o <= 1'b1;
          end else begin
            state_q <= ENG_IDLE;
          end
        end
        default: begin
          state_q <= ENG_HALT;
        end
      endcase
    end
  end

endmodule

// File: rtl/seq_event_slot.sv
module seq_event_slot #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [CNT_W-1:0] push_len_i,
  input  logic             pop_i,
  output logic             valid_o,
  output logic [CNT_W-1:0] len_o,
  output logic             ovf_o
);

  always_ff @(posedge clk) begin
    if (rst || flush_i) begin
      valid_o <= 1'b0;
      len_o   <= '0;
      ovf_o   <= 1'b0;
    end else begin
      ovf_o <= push_i && valid_o && !pop_i;
      if (pop_i && push_i) begin
        valid_o <= 1'b1;
        len_o   <= push_len_i;
      end else if (pop_i) begin
        valid_o <= 1'b0;
      end else if (push_i && !valid_o) begin
        valid_o <= 1'b1;
        len_o   <= push_len_i;
      end
    end
  end

endmodule

// File: rtl/seq_refill_decode.sv
module seq_refill_decode #(
  parameter int              CAUSE_W     = 4,
  parameter logic [(1<<CAUSE_W)-1:0] REFILL_MASK = '1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               op_valid_i,
  input  logic [CAUSE_W-1:0] op_cause_i,
  output logic               refill_o
);

  always_ff @(posedge clk) begin
    if (rst) refill_o <= 1'b0;
    else     refill_o <= op_valid_i && REFILL_MASK[op_cause_i];
  end

endmodule

// File: rtl/seq_strobe_encoder.sv
module seq_strobe_encoder
  import seq_strobe_pkg::*;
#(
  parameter int LEN_BOUNDARY = 1,
  parameter int LEN_DEFER    = 2,
  parameter int LEN_TRAP     = 3,
  parameter int GAP_CYCLES   = 1,
  parameter int CAUSE_W      = 4,
  parameter logic [(1<<CAUSE_W)-1:0] REFILL_MASK = 16'h01FE
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ev_valid_i,
  input  logic [1:0]         ev_kind_i,
  input  logic               halt_req_i,
  input  logic               op_valid_i,
  input  logic [CAUSE_W-1:0] op_cause_i,
  output logic               status_o,
  output logic               refill_o,
  output logic               busy_o,
  output logic               overflow_o
);

  localparam int LEN_MAX = max3(LEN_BOUNDARY, LEN_DEFER, LEN_TRAP);
  localparam int CNT_W   = $clog2(((LEN_MAX > GAP_CYCLES) ? LEN_MAX : GAP_CYCLES) + 1);

  logic             can_start, halted, active;
  logic             q_valid, q_ovf;
  logic [CNT_W-1:0] q_len;
  logic [CNT_W-1:0] in_len;
  logic             ev_ok, take_q, take_in, start, push;
  logic [CNT_W-1:0] start_len;
  ev_kind_e         kind;

  assign kind = ev_kind_e'(ev_kind_i);

  always_comb begin
    unique case (kind)
      EVK_PLAIN: in_len = CNT_W'(LEN_BOUNDARY);
      EVK_DEFER: in_len = CNT_W'(LEN_DEFER);
      EVK_TRAP:  in_len = CNT_W'(LEN_TRAP);
      default:   in_len = '0;
    endcase
  end

  assign ev_ok     = ev_valid_i && (kind != EVK_RSVD) && !halted && !halt_req_i;
  assign take_q    = can_start && q_valid && !halt_req_i;
  assign take_in   = can_start && !q_valid && ev_ok;
  assign start     = take_q || take_in;
  assign start_len = take_q ? q_len : in_len;
  assign push      = ev_ok && !take_in;

  seq_pulse_engine #(
    .CNT_W      (CNT_W),
    .GAP_CYCLES (GAP_CYCLES)
  ) u_engine (
    .clk         (clk),
    .rst         (rst),
    .halt_i      (halt_req_i),
    .start_i     (start),
    .start_len_i (start_len),
    .can_start_o (can_start),
    .status_o    (status_o),
    .halted_o    (halted),
    .active_o    (active)
  );

  seq_event_slot #(
    .CNT_W (CNT_W)
  ) u_slot (
    .clk        (clk),
    .rst        (rst),
    .flush_i    (halt_req_i),
    .push_i     (push),
    .push_len_i (in_len),
    .pop_i      (take_q),
    .valid_o    (q_valid),
    .len_o      (q_len),
    .ovf_o      (q_ovf)
  );

  seq_refill_decode #(
    .CAUSE_W     (CAUSE_W),
    .REFILL_MASK (REFILL_MASK)
  ) u_refill (
    .clk        (clk),
    .rst        (rst),
    .op_valid_i (op_valid_i),
    .op_cause_i (op_cause_i),
    .refill_o   (refill_o)
  );

  assign busy_o     = active || q_valid;
  assign overflow_o = q_ovf;

endmodule

// File: rtl/seq_strobe_encoder_chk.sv
module seq_strobe_encoder_chk #(
  parameter int LEN_BOUNDARY = 1,
  parameter int LEN_DEFER    = 2,
  parameter int LEN_TRAP     = 3,
  parameter int CAUSE_W      = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               halt_req_i,
  input logic               op_valid_i,
  input logic [CAUSE_W-1:0] op_cause_i,
  input logic               status_o,
  input logic               refill_o,
  input logic               busy_o,
  input logic               overflow_o,
  input logic               halted
);

  logic [7:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)                        run_q <= '0;
    else if (status_o && run_q != 8'hFF) run_q <= run_q + 8'd1;
    else if (!status_o)             run_q <= '0;
  end

  // R1 R2 R3: a finished pulse has one of the three coded lengths
  a_r1_r2_r3_pulse_len: assert property (@(posedge clk) disable iff (rst)
    (!status_o && run_q != 8'd0) |->
      (run_q == 8'(LEN_BOUNDARY) || run_q == 8'(LEN_DEFER) || run_q == 8'(LEN_TRAP)));

  a_r4_halt_takes_hold: assert property (@(posedge clk) disable iff (rst)
    halt_req_i |=> (status_o && halted));

  a_r4_halt_sticks: assert property (@(posedge clk) disable iff (rst)
    halted |=> (status_o && halted && busy_o && !overflow_o));

  a_r5_refill_has_cause: assert property (@(posedge clk) disable iff (rst)
    refill_o |-> $past(op_valid_i));

  a_r6_no_refill_cc_only: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && op_cause_i == '0) |=> !refill_o);

  a_r8_overflow_only_busy: assert property (@(posedge clk) disable iff (rst)
    overflow_o |-> $past(busy_o));

  a_r10_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!status_o && !refill_o && !busy_o && !overflow_o));

endmodule

bind seq_strobe_encoder seq_strobe_encoder_chk #(
  .LEN_BOUNDARY (LEN_BOUNDARY),
  .LEN_DEFER    (LEN_DEFER),
  .LEN_TRAP     (LEN_TRAP),
  .CAUSE_W      (CAUSE_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .halt_req_i (halt_req_i),
  .op_valid_i (op_valid_i),
  .op_cause_i (op_cause_i),
  .status_o   (status_o),
  .refill_o   (refill_o),
  .busy_o     (busy_o),
  .overflow_o (overflow_o),
  .halted     (halted)
);

// File: tb/test_seq_strobe_encoder.sv
`timescale 1ns/1ps
module test_seq_strobe_encoder;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ev_valid_i = 1'b0;
  logic [1:0] ev_kind_i = 2'd0;
  logic       halt_req_i = 1'b0;
  logic       op_valid_i = 1'b0;
  logic [3:0] op_cause_i = 4'd0;
  logic       status_o, refill_o, busy_o, overflow_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  seq_strobe_encoder i_seq_strobe_encoder (
    .clk        (clk),
    .rst        (rst),
    .ev_valid_i (ev_valid_i),
    .ev_kind_i  (ev_kind_i),
    .halt_req_i (halt_req_i),
    .op_valid_i (op_valid_i),
    .op_cause_i (op_cause_i),
    .status_o   (status_o),
    .refill_o   (refill_o),
    .busy_o     (busy_o),
    .overflow_o (overflow_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    ev_valid_i = 1'b0;
    halt_req_i = 1'b0;
    op_valid_i = 1'b0;
    @(negedge clk);
    check("R10 status after reset", status_o, 0);
    check("R10 refill after reset", refill_o, 0);
    check("R10 busy after reset", busy_o, 0);
    check("R10 overflow after reset", overflow_o, 0);
    rst = 1'b0;
  endtask

  // Single event into an idle encoder: measure its high run and busy tail
  task automatic t_single(input logic [1:0] kind, input int exp_len, input string req);
    int len;
    @(negedge clk);
    ev_valid_i = 1'b1;
    ev_kind_i  = kind;
    @(negedge clk);
    ev_valid_i = 1'b0;
    check({req, " first clock high"}, status_o, 1);
    len = 0;
    while (status_o && len < 10) begin
      check("R9 busy during pulse", busy_o, 1);
      len++;
      @(negedge clk);
    end
    check({req, " pulse length"}, len, exp_len);
    check("R9 busy in gap", busy_o, 1);
    @(negedge clk);
    check("R9 busy clears after gap", busy_o, 0);
  endtask

  task automatic t_back_to_back();
    logic [6:0] tr;
    @(negedge clk);
    ev_valid_i = 1'b1; ev_kind_i = 2'd2;
    @(negedge clk);
    ev_kind_i = 2'd0;
    for (int i = 0; i < 7; i++) begin
      tr[i] = status_o;
      if (i == 5) check("R9 busy in final gap", busy_o, 1);
      if (i == 6) check("R9 busy idle after pair", busy_o, 0);
      if (i == 0) begin
        @(negedge clk);
        ev_valid_i = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    // samples: 1,1,1 (R3) 0 (R7 gap) 1 (R1 queued) 0 0
    check("R7 back-to-back trace", tr, 7'b0010111);
  endtask

  task automatic t_overflow();
    logic [7:0] tr;
    logic [7:0] ov;
    @(negedge clk);
    ev_valid_i = 1'b1; ev_kind_i = 2'd2;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      tr[i] = status_o;
      ov[i] = overflow_o;
      if (i == 0) ev_kind_i = 2'd1;
      if (i == 1) ev_kind_i = 2'd0;
      if (i == 2) ev_valid_i = 1'b0;
    end
    // A: 3 high, gap, B: 2 high, gap, C dropped
    check("R8 trace with dropped event", tr, 8'b00110111);
    check("R8 overflow pulse timing", ov, 8'b00000100);
    check("R8 busy idle at end", busy_o, 0);
  endtask

  task automatic t_reserved();
    @(negedge clk);
    ev_valid_i = 1'b1; ev_kind_i = 2'd3;
    @(negedge clk);
    ev_valid_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      check("R11 reserved kind no pulse", status_o, 0);
      check("R11 reserved kind not busy", busy_o, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_refill();
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      op_valid_i = 1'b1;
      op_cause_i = 4'(c);
      @(negedge clk);
      op_valid_i = 1'b0;
      if (c >= 1 && c <= 8) check($sformatf("R5 refill cause %0d", c), refill_o, 1);
      else                  check($sformatf("R6 no refill cause %0d", c), refill_o, 0);
      @(negedge clk);
      check("R5 refill one clock", refill_o, 0);
    end
  endtask

  task automatic t_halt();
    int highs;
    int ovs;
    @(negedge clk);
    ev_valid_i = 1'b1; ev_kind_i = 2'd2;
    @(negedge clk);
    ev_kind_i = 2'd0;           // waits in the slot
    @(negedge clk);
    ev_valid_i = 1'b0;
    halt_req_i = 1'b1;
    @(negedge clk);
    halt_req_i = 1'b0;
    highs = 0; ovs = 0;
    for (int i = 0; i < 20; i++) begin
      if (i == 5) begin ev_valid_i = 1'b1; ev_kind_i = 2'd1; end
      if (i == 8) ev_valid_i = 1'b0;
      highs += status_o;
      ovs   += overflow_o;
      @(negedge clk);
    end
    check("R4 status held in halt", highs, 20);
    check("R4 no overflow in halt", ovs, 0);
    check("R4 busy in halt", busy_o, 1);
    do_reset();
    t_single(2'd0, 1, "R10 R1 after halt cleared");
  endtask

  initial begin
    do_reset();
    t_single(2'd0, 1, "R1");
    t_single(2'd1, 2, "R2");
    t_single(2'd2, 3, "R3");
    t_back_to_back();
    t_overflow();
    t_reserved();
    t_refill();
    t_halt();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule